// File: doc/BRIEF.md
# Hardware Return Address Shadow Stack

This block guards the return addresses of a simple processor. It watches the call and return events that retire from the pipeline. On a call, it writes the return address into a small on-chip store that only it can write, and advances its own depth pointer. On a return, it removes the newest entry and compares it with the return target that the core read from the ordinary stack. If the two differ, the block raises a control-protection fault.

The block also screens the core's ordinary store requests against an address window that stands for the shadow region. A store aimed inside that window is refused at once and is reported as an illegal store. The depth pointer and the stored entries change only through call and return events. Faults are one-cycle pulses that carry a two-bit cause. A global check-enable input can silence fault reporting while the stack keeps tracking.

Top module: `shadow_ret_stack`

## Requirements
- R1: A call event (`call_vld`) with room left writes `call_addr` as the newest entry, and `sp_depth` is one higher after the clock edge.
- R2: A return event (`ret_vld`) on a non-empty stack removes the newest entry, and `sp_depth` is one lower after the edge. When that entry equals `ret_target`, no fault is raised.
- R3: When the removed entry differs from `ret_target`, a fault with cause 0 (mismatch) is raised. The entry is still consumed.
- R4: A call while `sp_depth` equals DEPTH (and no return in the same cycle) raises cause 1 (overflow). It leaves `sp_depth` and every stored entry unchanged.
- R5: A return while `sp_depth` is 0 raises cause 2 (underflow), and `sp_depth` stays 0.
- R6: `st_block` is high exactly when `st_req` is high and `st_addr` lies in [REGION_BASE, REGION_BASE+REGION_SIZE-1]. `st_pass` is high when `st_req` is high and the address lies outside that window. Both are combinational, in the same cycle.
- R7: A blocked store raises cause 3 (illegal store). This cause has the lowest priority: a return fault (cause 0 or 2) or an overflow in the same cycle is reported instead.
- R8: `fault_vld` is a pulse in the cycle after the offending event, and it lasts one cycle unless a new fault event follows.
- R9: When a call and a return arrive in the same cycle, the return is handled first, against the old newest entry. The call then pushes into the freed slot. A full stack therefore takes the push without overflow, and an empty stack reports underflow and still takes the push.
- R10: While `chk_en` is low, `fault_vld` stays low, but pushes, pops and store blocking behave as when enabled.
- R11: After reset, `sp_depth` is 0 and `fault_vld` is low.
- R12: Store requests never change `sp_depth` or the stored entries, whether they are blocked or passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_en | input | 1 | Enables fault reporting |
| call_vld | input | 1 | A call retires this cycle |
| call_addr | input | AW | Return address saved by the call |
| ret_vld | input | 1 | A return retires this cycle |
| ret_target | input | AW | Return address read from the ordinary stack |
| st_req | input | 1 | Ordinary store request |
| st_addr | input | AW | Store target address |
| st_pass | output | 1 | Store may proceed |
| st_block | output | 1 | Store refused: it targets the shadow region |
| fault_vld | output | 1 | Fault pulse |
| fault_cause | output | 2 | 0 mismatch, 1 overflow, 2 underflow, 3 illegal store |
| sp_depth | output | clog2(DEPTH+1) | Number of entries held |

## Verification
A wrong depth pointer shows on `sp_depth` one edge after the event that caused it. It also shows later, as a false underflow, a missed overflow, or a mismatch on a return whose target was correct. A corrupted or misplaced entry stays hidden until the return that consumes it. That return then reports a mismatch one cycle later. For this reason the bench keeps pairing pushes with pops of the expected target, so every stored word is read back. A faulty cause encoder or a faulty priority between causes shows on `fault_cause` in the cycle after two events collide.

// File: rtl/ssk_pkg.sv
// Shared definitions for the shadow return-address stack.
// Assumes: fault causes fit in two bits, and their numbering is visible at the ports.
package ssk_pkg;

    typedef enum logic [1:0] {
        CAUSE_MISMATCH  = 2'd0,
        CAUSE_OVERFLOW  = 2'd1,
        CAUSE_UNDERFLOW = 2'd2,
        CAUSE_BADSTORE  = 2'd3
    } ssk_cause_e;

endpackage

// File: rtl/ssk_region_filter.sv
// Store screen: refuses any ordinary store whose address falls inside the
// shadow window [BASE, BASE+SIZE-1]. Purely combinational.
// Assumes: BASE+SIZE-1 does not wrap past the top of the address space.
module ssk_region_filter #(
    parameter int             AW   = 32,
    parameter logic [AW-1:0]  BASE = '0,
    parameter logic [AW-1:0]  SIZE = 1
) (
    input  logic          req,
    input  logic [AW-1:0] addr,
    output logic          pass,
    output logic          block
);
    localparam logic [AW-1:0] LAST = BASE + SIZE - 1'b1;

    logic hit;

    // Window hit test and pass/block split of the request.
    always_comb begin
        hit   = (addr >= BASE) && (addr <= LAST);
        block = req && hit;
        pass  = req && !hit;
    end
endmodule

// File: rtl/ssk_ptr.sv
// Depth pointer of the shadow stack. It decides, per cycle, whether the
// return pops or underflows and whether the call pushes or overflows.
// The return is ordered before the call. Only call/return events move it.
// Assumes: DEPTH >= 2.
module ssk_ptr #(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1),
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_vld,
    input  logic          ret_vld,
    output logic [LW-1:0] level,
    output logic          pop_ok,
    output logic          underflow,
    output logic          push_ok,
    output logic          overflow,
    output logic [IW-1:0] rd_idx,
    output logic [IW-1:0] wr_idx
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    logic [LW-1:0] after_pop;
    logic [LW-1:0] level_nxt;

    // Return first: pop or underflow, then see if the call still fits.
    always_comb begin
        underflow = ret_vld && (level == '0);
        pop_ok    = ret_vld && (level != '0);
        after_pop = level - LW'(pop_ok);
        overflow  = call_vld && (after_pop == FULL);
        push_ok   = call_vld && !overflow;
        level_nxt = after_pop + LW'(push_ok);
        rd_idx    = IW'(level) - IW'(1);
        wr_idx    = IW'(after_pop);
    end

    // Pointer register, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
        end else begin
            level <= level_nxt;
        end
    end
endmodule

// File: rtl/ssk_slots.sv
// Entry storage: DEPTH words of return addresses, one write port, one read port.
// Only the push path of the block drives the write port.
// Assumes: the contents need no reset; the pointer marks which slots are valid.
module ssk_slots #(
    parameter int AW    = 32,
    parameter int DEPTH = 16,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [IW-1:0] widx,
    input  logic [AW-1:0] wdata,
    input  logic [IW-1:0] ridx,
    output logic [AW-1:0] rdata
);
    logic [AW-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        // Each slot loads only when it is the push target.
        always_ff @(posedge clk) begin
            if (we && (widx == IW'(i))) begin
                slot[i] <= wdata;
            end
        end
    end

    // Read the entry at the top of the stack.
    always_comb begin
        rdata = slot[ridx];
    end
endmodule

// File: rtl/ssk_fault_gen.sv
// Fault reporter: turns the event flags of one cycle into a registered
// one-cycle pulse and cause code. Priority: underflow/mismatch (these
// exclude each other), then overflow, then illegal store.
// Assumes: the flags are valid in the cycle of their event.
module ssk_fault_gen
    import ssk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       mismatch,
    input  logic       underflow,
    input  logic       overflow,
    input  logic       badstore,
    output logic       fault_vld,
    output ssk_cause_e fault_cause
);
    ssk_cause_e sel;
    logic       any;

    // Choose the cause with the highest priority.
    always_comb begin
        any = mismatch || underflow || overflow || badstore;
        if (underflow)     sel = CAUSE_UNDERFLOW;
        else if (mismatch) sel = CAUSE_MISMATCH;
        else if (overflow) sel = CAUSE_OVERFLOW;
        else               sel = CAUSE_BADSTORE;
    end

    // Register the pulse; a low enable masks it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_vld   <= 1'b0;
            fault_cause <= CAUSE_MISMATCH;
        end else begin
            fault_vld   <= en && any;
            fault_cause <= sel;
        end
    end
endmodule

// File: rtl/shadow_ret_stack.sv
// Top of the return-address shadow stack. Calls push, returns pop and
// compare, and ordinary stores are screened against the shadow window.
// Faults are reported one cycle after their event.
// Assumes: at most one call and one return retire per cycle, and DEPTH >= 2.
module shadow_ret_stack
    import ssk_pkg::*;
#(
    parameter int            AW          = 32,
    parameter int            DEPTH       = 16,
    parameter logic [AW-1:0] REGION_BASE = 32'h0000_F000,
    parameter logic [AW-1:0] REGION_SIZE = 32'h0000_0100,
    localparam int           LW          = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chk_en,
    input  logic          call_vld,
    input  logic [AW-1:0] call_addr,
    input  logic          ret_vld,
    input  logic [AW-1:0] ret_target,
    input  logic          st_req,
    input  logic [AW-1:0] st_addr,
    output logic          st_pass,
    output logic          st_block,
    output logic          fault_vld,
    output logic [1:0]    fault_cause,
    output logic [LW-1:0] sp_depth
);
    localparam int IW = $clog2(DEPTH);

    logic          pop_ok, underflow, push_ok, overflow, mismatch;
    logic [IW-1:0] rd_idx, wr_idx;
    logic [AW-1:0] top_word;
    ssk_cause_e    cause_q;

    ssk_ptr #(.DEPTH(DEPTH), .LW(LW), .IW(IW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .call_vld  (call_vld),
        .ret_vld   (ret_vld),
        .level     (sp_depth),
        .pop_ok    (pop_ok),
        .underflow (underflow),
        .push_ok   (push_ok),
        .overflow  (overflow),
        .rd_idx    (rd_idx),
        .wr_idx    (wr_idx)
    );

    ssk_slots #(.AW(AW), .DEPTH(DEPTH), .IW(IW)) u_slots (
        .clk   (clk),
        .we    (push_ok),
        .widx  (wr_idx),
        .wdata (call_addr),
        .ridx  (rd_idx),
        .rdata (top_word)
    );

    ssk_region_filter #(.AW(AW), .BASE(REGION_BASE), .SIZE(REGION_SIZE)) u_filter (
        .req   (st_req),
        .addr  (st_addr),
        .pass  (st_pass),
        .block (st_block)
    );

    // Compare the popped entry with the target taken from the ordinary stack.
    always_comb begin
        mismatch = pop_ok && (top_word != ret_target);
    end

    ssk_fault_gen u_fault (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (chk_en),
        .mismatch    (mismatch),
        .underflow   (underflow),
        .overflow    (overflow),
        .badstore    (st_block),
        .fault_vld   (fault_vld),
        .fault_cause (cause_q)
    );

    // Present the cause as a plain vector at the port.
    always_comb begin
        fault_cause = cause_q;
    end
endmodule

// File: rtl/ssk_checker.sv
// Port-level properties of the shadow stack, bound to every instance.
module ssk_checker
    import ssk_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          chk_en,
    input logic          call_vld,
    input logic          ret_vld,
    input logic          st_req,
    input logic          st_pass,
    input logic          st_block,
    input logic          fault_vld,
    input logic [1:0]    fault_cause,
    input logic [LW-1:0] sp_depth
);
    localparam logic [LW-1:0] FULL = LW'(DEPTH);

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
        call_vld && !ret_vld && (sp_depth != FULL) |=> sp_depth == $past(sp_depth) + 1'b1); // R1

    AST_POP_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        ret_vld && !call_vld && (sp_depth != '0) |=> sp_depth == $past(sp_depth) - 1'b1); // R2

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        call_vld && !ret_vld && (sp_depth == FULL) |=> sp_depth == FULL); // R4

    AST_OVERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en && call_vld && !ret_vld && (sp_depth == FULL)
        |=> fault_vld && (fault_cause == CAUSE_OVERFLOW)); // R4

    AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        chk_en && ret_vld && (sp_depth == '0) |=> fault_vld && (fault_cause == CAUSE_UNDERFLOW)); // R5

    AST_STORE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
        !(st_pass && st_block) && ((st_pass || st_block) == st_req)); // R6

    AST_SAME_CYCLE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        call_vld && ret_vld && (sp_depth == FULL) |=> sp_depth == FULL); // R9

    AST_QUIET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_en |=> !fault_vld); // R10

    AST_STORE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        st_req && !call_vld && !ret_vld |=> $stable(sp_depth)); // R12
endmodule

bind shadow_ret_stack ssk_checker #(.DEPTH(DEPTH), .LW(LW)) u_ssk_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .chk_en      (chk_en),
    .call_vld    (call_vld),
    .ret_vld     (ret_vld),
    .st_req      (st_req),
    .st_pass     (st_pass),
    .st_block    (st_block),
    .fault_vld   (fault_vld),
    .fault_cause (fault_cause),
    .sp_depth    (sp_depth)
);

// File: tb/test_shadow_ret_stack.sv
// Bench: a queue-based reference model steps with the design, and the
// outputs are compared on every clock, away from the rising edge.
module test_shadow_ret_stack;
    localparam int            CLK_PERIOD = 10;
    localparam int            AW         = 32;
    localparam int            DEPTH      = 8;
    localparam int            LW         = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] RBASE      = 32'h0000_4000;
    localparam logic [AW-1:0] RSIZE      = 32'h0000_0040;
    localparam logic [AW-1:0] RLAST      = RBASE + RSIZE - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          chk_en = 1'b1;
    logic          call_vld = 1'b0;
    logic [AW-1:0] call_addr = '0;
    logic          ret_vld = 1'b0;
    logic [AW-1:0] ret_target = '0;
    logic          st_req = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic          st_pass, st_block, fault_vld;
    logic [1:0]    fault_cause;
    logic [LW-1:0] sp_depth;

    shadow_ret_stack #(.AW(AW), .DEPTH(DEPTH), .REGION_BASE(RBASE), .REGION_SIZE(RSIZE))
        i_shadow_ret_stack (
        .clk(clk), .rst_n(rst_n), .chk_en(chk_en),
        .call_vld(call_vld), .call_addr(call_addr),
        .ret_vld(ret_vld), .ret_target(ret_target),
        .st_req(st_req), .st_addr(st_addr),
        .st_pass(st_pass), .st_block(st_block),
        .fault_vld(fault_vld), .fault_cause(fault_cause), .sp_depth(sp_depth)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int            checks = 0;
    int            errors = 0;
    bit            done = 0;
    logic [AW-1:0] model_q[$];
    int            exp_level = 0;
    bit            exp_vld = 0;
    int            exp_cause = 0;
    string         prev_tag = "R11";

    task automatic chk(string tag, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [AW-1:0] top_word();
        return (model_q.size() > 0) ? model_q[$] : '0;
    endfunction

    // One cycle: check the last results, drive new inputs, advance the model.
    task automatic step(string tag, bit c, logic [AW-1:0] ca, bit r, logic [AW-1:0] rt,
                        bit s, logic [AW-1:0] sa, bit en);
        bit in_win, f_ovf, f_udf, f_mis;
        @(negedge clk);
        chk(prev_tag, "sp_depth", sp_depth, exp_level);
        chk(prev_tag, "fault_vld", fault_vld, exp_vld);
        if (exp_vld) chk(prev_tag, "fault_cause", fault_cause, exp_cause);
        call_vld = c; call_addr = ca; ret_vld = r; ret_target = rt;
        st_req = s; st_addr = sa; chk_en = en;
        #1;
        in_win = s && (sa >= RBASE) && (sa <= RLAST);
        chk("R6", "st_block", st_block, in_win);
        chk("R6", "st_pass", st_pass, s && !in_win);
        f_ovf = 0; f_udf = 0; f_mis = 0;
        if (r) begin
            if (model_q.size() == 0) f_udf = 1;
            else if (model_q.pop_back() != rt) f_mis = 1;
        end
        if (c) begin
            if (model_q.size() == DEPTH) f_ovf = 1;
            else model_q.push_back(ca);
        end
        exp_level = model_q.size();
        exp_vld   = en && (f_ovf || f_udf || f_mis || in_win);
        exp_cause = f_udf ? 2 : f_mis ? 0 : f_ovf ? 1 : 3;
        prev_tag  = tag;
    endtask

    task automatic idle(string tag);
        step(tag, 0, '0, 0, '0, 0, '0, 1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R11: reset state is checked by the first step.
        idle("R11");
        // R1 pushes, then R2 a correct pop.
        step("R1", 1, 32'h1000, 0, '0, 0, '0, 1);
        step("R1", 1, 32'h1004, 0, '0, 0, '0, 1);
        step("R1", 1, 32'h1008, 0, '0, 0, '0, 1);
        step("R2", 0, '0, 1, 32'h1008, 0, '0, 1);
        // R3 mismatch consumes the entry; the next pop matches the one below.
        step("R3", 0, '0, 1, 32'hdead, 0, '0, 1);
        idle("R8");
        step("R3", 0, '0, 1, 32'h1000, 0, '0, 1);
        // R5 underflow on empty, twice back to back (R8 pulse per event).
        step("R5", 0, '0, 1, 32'h1, 0, '0, 1);
        step("R5", 0, '0, 1, 32'h2, 0, '0, 1);
        idle("R8");
        // R4 fill, overflow, then check that contents are intact.
        for (int i = 0; i < DEPTH; i++) step("R4", 1, 32'h2000 + 4 * i, 0, '0, 0, '0, 1);
        step("R4", 1, 32'hbad0, 0, '0, 0, '0, 1);
        step("R4", 0, '0, 1, top_word(), 0, '0, 1);
        step("R4", 1, 32'h2100, 0, '0, 0, '0, 1);
        // R9 call and return together on a full stack.
        step("R9", 1, 32'h3000, 1, 32'h2100, 0, '0, 1);
        step("R9", 0, '0, 1, 32'h3000, 0, '0, 1);
        while (model_q.size() > 0) step("R2", 0, '0, 1, top_word(), 0, '0, 1);
        // R9 together on an empty stack: underflow and still a push.
        step("R9", 1, 32'h3100, 1, 32'h0, 0, '0, 1);
        step("R9", 0, '0, 1, 32'h3100, 0, '0, 1);
        // R6/R7 window edges.
        step("R7", 0, '0, 0, '0, 1, RBASE - 1, 1);
        step("R7", 0, '0, 0, '0, 1, RBASE, 1);
        step("R7", 0, '0, 0, '0, 1, RLAST, 1);
        step("R7", 0, '0, 0, '0, 1, RSIZE + RBASE, 1);
        step("R6", 0, '0, 0, '0, 0, RBASE, 1);
        // R12 stores leave the depth and contents alone; R7 priority versus mismatch.
        step("R12", 1, 32'h4444, 0, '0, 0, '0, 1);
        step("R12", 0, '0, 0, '0, 1, RBASE + 4, 1);
        step("R12", 0, '0, 0, '0, 1, 32'h10, 1);
        step("R12", 0, '0, 1, 32'h4444, 0, '0, 1);
        step("R7", 1, 32'h5555, 0, '0, 0, '0, 1);
        step("R7", 0, '0, 1, 32'h0bad, 1, RBASE, 1);
        step("R7", 0, '0, 1, 32'h0, 1, RBASE, 1);
        // R10 disabled: mismatch, underflow and bad store are silent.
        step("R10", 1, 32'h6000, 0, '0, 0, '0, 0);
        step("R10", 0, '0, 1, 32'h7777, 1, RBASE, 0);
        step("R10", 0, '0, 1, 32'h0, 0, '0, 0);
        idle("R10");
        // Random traffic covering R1 R2 R3 R4 R5 R9.
        for (int n = 0; n < 600; n++) begin
            bit            c = ($urandom_range(0, 9) < 5);
            bit            r = ($urandom_range(0, 9) < 4);
            bit            s = ($urandom_range(0, 9) < 3);
            logic [AW-1:0] rt = ($urandom_range(0, 9) != 0) ? top_word() : $urandom;
            logic [AW-1:0] sa = RBASE - 8 + $urandom_range(0, RSIZE + 16);
            step("R1 R2 R3 R9 random", c, $urandom, r, rt, s, sa, ($urandom_range(0, 9) != 0));
        end
        idle("random");
        idle("random");
        finish_run();
    end
endmodule